// File: doc/BRIEF.md
# Four-Phase Handshake Bridge to Synchronous Memory

The bridge lets a processor that speaks a four-phase request/acknowledge protocol reach a clocked single-port ROM and a clocked single-port RAM. An instruction fetch raises two ROM requests, one for the address and one for the data. A C-element merges them. Once the merged request is accepted, the ROM is enabled. After a fixed ready latency the ROM raises its ready flag. One clock later both ROM acknowledges go high, and the read word sits on the data output. When the processor lowers its requests, the merged request falls, the enable drops, ready falls on the next edge, and the acknowledges clear at once without waiting for another edge.

The RAM side has a read request and a write request. They are ORed into one RAM request. A read/not-write bit chooses the direction, and a single acknowledge answers either kind of access. The ROM contents are produced by a function of the address rather than stored. The RAM is a plain array. A new access is accepted only after the previous acknowledges have gone low, so the four-phase protocol stays strict.

Top module: `hs_mem_bridge`

## Requirements
- R1: A ROM access returns the word `(addr*37 + 90) mod 256` on `rom_rdata`, where `addr` is the value held on `rom_addr` during the access.
- R2: The merged ROM request rises only when both ROM requests are high. It falls only when both are low, and otherwise it keeps its value. In particular, lowering one request while both acknowledges are high leaves both acknowledges high.
- R3: While only one of the two ROM requests is high, the ROM is not enabled and neither ROM acknowledge rises.
- R4: Both ROM acknowledges rise on the clock edge that follows the first edge at which the memory ready flag is high. Counted from the first edge that samples the request(s) high, an access is acknowledged after exactly LAT+2 edges (3 with the default LAT=1).
- R5: The acknowledges clear in the same step in which ready falls. After the requests are lowered, they are still high after one edge and low after the second edge.
- R6: Either the RAM read request or the RAM write request alone starts a RAM access, which is acknowledged on `ram_ack` with the same LAT+2 timing.
- R7: During a RAM access, `ram_rnw`=0 writes `ram_wdata` to `ram_addr`. `ram_rnw`=1 returns the stored word on `ram_rdata`.
- R8: Read data is valid when the data acknowledge rises. It stays unchanged while that acknowledge is high and through its fall.
- R9: A request raised again before the previous acknowledges have cleared is not started until they are low. It then completes with the correct data after LAT+3 edges.
- R10: While `rst_n` is low, all acknowledges and both read-data outputs are 0. Asserting reset in the middle of an access clears the acknowledges immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_areq | input | 1 | ROM address request |
| rom_dreq | input | 1 | ROM data request |
| rom_addr | input | AW | ROM word address |
| rom_aack | output | 1 | ROM address acknowledge |
| rom_dack | output | 1 | ROM data acknowledge |
| rom_rdata | output | DW | ROM read word |
| ram_rreq | input | 1 | RAM read request |
| ram_wreq | input | 1 | RAM write request |
| ram_rnw | input | 1 | RAM direction: 1 read, 0 write |
| ram_addr | input | AW | RAM word address |
| ram_wdata | input | DW | RAM write word |
| ram_ack | output | 1 | RAM acknowledge |
| ram_rdata | output | DW | RAM read word |

## Verification
The bench holds one ROM request high on its own and expects silence. A bridge that ORed the two ROM requests would acknowledge at that point. It then drops one request while the acknowledges are high and expects them to stay up; a plain AND would release them early. The bench times the return to zero to the edge, which exposes acknowledges cleared one clock late or cleared before ready falls. It also re-requests a new address before the old acknowledges have cleared. A bridge that is not strict would either lose that access or hand back the stale word.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

  // ROM contents as a function of the word address
  function automatic logic [7:0] rom_word(input int unsigned a);
    return 8'(a * 37 + 90);
  endfunction

  // Muller C-element next state
  function automatic logic c_next(input logic a, input logic b, input logic prev);
    if (a && b)        return 1'b1;
    else if (!a && !b) return 1'b0;
    else               return prev;
  endfunction

endpackage

// File: rtl/mbr_cjoin.sv
module mbr_cjoin (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic y_nxt,
  output logic y
);
  import mbr_pkg::*;

  assign y_nxt = c_next(a, b, y);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y <= 1'b0;
    else        y <= y_nxt;
  end
endmodule

// File: rtl/mbr_gate.sv
module mbr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic hold,
  output logic en
);
  // a new access starts only when no acknowledge is still up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en <= 1'b0;
    else if (en) en <= req;
    else         en <= req & ~hold;
  end
endmodule

// File: rtl/mbr_mem.sv
module mbr_mem #(
  parameter int AW       = 6,
  parameter int DW       = 8,
  parameter int LAT      = 1,
  parameter bit WRITABLE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rnw,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          rdy,
  output logic [DW-1:0] rdata
);
  import mbr_pkg::*;

  localparam int DEPTH = 1 << AW;
  localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] rd_val;
  logic          fire;

  assign fire = en & ~rdy & (cnt == LAST);

  generate
    if (WRITABLE) begin : g_ram
      logic [DW-1:0] mem [DEPTH];
      assign rd_val = mem[addr];
      always_ff @(posedge clk) begin
        if (fire && !rnw) mem[addr] <= wdata;
      end
    end else begin : g_rom
      logic unused_rom;
      assign unused_rom = ^{wdata, rnw};
      assign rd_val = DW'(rom_word(32'(addr)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy   <= 1'b0;
      cnt   <= '0;
      rdata <= '0;
    end else if (!en) begin
      rdy <= 1'b0;
      cnt <= '0;
    end else if (fire) begin
      rdy <= 1'b1;
      cnt <= '0;
      if (rnw) rdata <= rd_val;
    end else if (!rdy) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mbr_ack.sv
module mbr_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy,
  output logic ack
);
  logic clr_n;
  assign clr_n = rst_n & rdy;

  // set one edge after ready, cleared without a clock when ready drops
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) ack <= 1'b0;
    else        ack <= 1'b1;
  end
endmodule

// File: rtl/hs_mem_bridge.sv
module hs_mem_bridge #(
  parameter int AW  = 6,
  parameter int DW  = 8,
  parameter int LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rom_areq,
  input  logic          rom_dreq,
  input  logic [AW-1:0] rom_addr,
  output logic          rom_aack,
  output logic          rom_dack,
  output logic [DW-1:0] rom_rdata,
  input  logic          ram_rreq,
  input  logic          ram_wreq,
  input  logic          ram_rnw,
  input  logic [AW-1:0] ram_addr,
  input  logic [DW-1:0] ram_wdata,
  output logic          ram_ack,
  output logic [DW-1:0] ram_rdata
);
  localparam int NROMACK = 2;

  logic               rom_join_nxt, rom_join, rom_en, rom_rdy;
  logic [NROMACK-1:0] rom_ack;
  logic               ram_req, ram_en, ram_rdy;

  mbr_cjoin u_cjoin (
    .clk(clk), .rst_n(rst_n), .a(rom_areq), .b(rom_dreq),
    .y_nxt(rom_join_nxt), .y(rom_join)
  );

  mbr_gate u_rom_gate (
    .clk(clk), .rst_n(rst_n), .req(rom_join_nxt), .hold(|rom_ack), .en(rom_en)
  );

  mbr_mem #(.AW(AW), .DW(DW), .LAT(LAT), .WRITABLE(1'b0)) u_rom (
    .clk(clk), .rst_n(rst_n), .en(rom_en), .rnw(1'b1), .addr(rom_addr),
    .wdata('0), .rdy(rom_rdy), .rdata(rom_rdata)
  );

  generate
    for (genvar i = 0; i < NROMACK; i++) begin : g_rom_ack
      mbr_ack u_ack (.clk(clk), .rst_n(rst_n), .rdy(rom_rdy), .ack(rom_ack[i]));
    end
  endgenerate

  assign rom_aack = rom_ack[0];
  assign rom_dack = rom_ack[1];

  assign ram_req = ram_rreq | ram_wreq;

  mbr_gate u_ram_gate (
    .clk(clk), .rst_n(rst_n), .req(ram_req), .hold(ram_ack), .en(ram_en)
  );

  mbr_mem #(.AW(AW), .DW(DW), .LAT(LAT), .WRITABLE(1'b1)) u_ram (
    .clk(clk), .rst_n(rst_n), .en(ram_en), .rnw(ram_rnw), .addr(ram_addr),
    .wdata(ram_wdata), .rdy(ram_rdy), .rdata(ram_rdata)
  );

  mbr_ack u_ram_ack (.clk(clk), .rst_n(rst_n), .rdy(ram_rdy), .ack(ram_ack));
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker #(
  parameter int DW  = 8,
  parameter int LAT = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rom_areq,
  input logic          rom_dreq,
  input logic          rom_join,
  input logic          rom_en,
  input logic          rom_rdy,
  input logic          rom_aack,
  input logic          rom_dack,
  input logic [DW-1:0] rom_rdata,
  input logic          ram_rreq,
  input logic          ram_wreq,
  input logic          ram_en,
  input logic          ram_rdy,
  input logic          ram_ack
);
  int unsigned wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     wait_cnt <= 0;
    else if (!rom_en || rom_dack)   wait_cnt <= 0;
    else                            wait_cnt <= wait_cnt + 1;
  end

  assert_join_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_join) |-> $past(rom_areq && rom_dreq));

  assert_join_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_join) |-> $past(!rom_areq && !rom_dreq));

  assert_single_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_areq != rom_dreq) && !rom_join |=> !rom_join);

  assert_ack_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_dack) |-> $past(rom_rdy));

  assert_rom_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= LAT + 1);

  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_rdy |-> !rom_aack && !rom_dack);

  assert_ram_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_rdy |-> !ram_ack);

  assert_ram_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_en) |-> $past(ram_rreq || ram_wreq));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_dack && $past(rom_dack) |-> $stable(rom_rdata));

  assert_strict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_en) |-> !rom_aack && !rom_dack);
endmodule

bind hs_mem_bridge mbr_checker #(.DW(DW), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rom_areq(rom_areq), .rom_dreq(rom_dreq),
  .rom_join(rom_join), .rom_en(rom_en), .rom_rdy(rom_rdy),
  .rom_aack(rom_aack), .rom_dack(rom_dack), .rom_rdata(rom_rdata),
  .ram_rreq(ram_rreq), .ram_wreq(ram_wreq), .ram_en(ram_en),
  .ram_rdy(ram_rdy), .ram_ack(ram_ack)
);

// File: tb/sim_hs_mem_bridge.sv
module sim_hs_mem_bridge;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int LAT = 1;
  localparam int NVEC = 9;

  // {op, addr, data}: op 0 ROM read, 1 RAM write, 2 RAM read (data = expected)
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd0, 6'd0,  8'h00}, {2'd0, 6'd63, 8'h00}, {2'd1, 6'd5,  8'hA5},
    {2'd1, 6'd63, 8'h3C}, {2'd2, 6'd5,  8'hA5}, {2'd0, 6'd21, 8'h00},
    {2'd2, 6'd63, 8'h3C}, {2'd1, 6'd5,  8'h00}, {2'd2, 6'd5,  8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rom_areq = 0, rom_dreq = 0, ram_rreq = 0, ram_wreq = 0, ram_rnw = 1;
  logic [AW-1:0] rom_addr = '0, ram_addr = '0;
  logic [DW-1:0] ram_wdata = '0;
  logic rom_aack, rom_dack, ram_ack;
  logic [DW-1:0] rom_rdata, ram_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hs_mem_bridge #(.AW(AW), .DW(DW), .LAT(LAT)) u0 (.*);

  function automatic logic [7:0] exp_rom(input int a);
    return 8'(((a << 5) + (a << 2) + a + 90) % 256);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ack(input bit rom, output int lat);
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (rom ? rom_dack : ram_ack) break;
    end
  endtask

  task automatic rom_access(input logic [AW-1:0] a);
    int lat;
    logic [DW-1:0] d;
    @(negedge clk);
    rom_addr = a; rom_areq = 1; rom_dreq = 1;
    wait_ack(1, lat);
    d = rom_rdata;
    check("R4 rom latency", lat, LAT + 2);
    check("R4 aack with dack", int'(rom_aack), 1);
    check("R1 rom word", int'(d), int'(exp_rom(int'(a))));
    rom_areq = 0; rom_dreq = 0;
    @(negedge clk);
    check("R5 acks held one edge", int'({rom_aack, rom_dack}), 3);
    check("R8 data held", int'(rom_rdata), int'(d));
    @(negedge clk);
    check("R5 acks cleared", int'({rom_aack, rom_dack}), 0);
    check("R8 data after fall", int'(rom_rdata), int'(d));
  endtask

  task automatic ram_access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] v);
    int lat;
    @(negedge clk);
    ram_addr = a; ram_wdata = v; ram_rnw = !wr; ram_rreq = !wr; ram_wreq = wr;
    wait_ack(0, lat);
    check("R6 ram latency", lat, LAT + 2);
    if (!wr) check("R7 ram read", int'(ram_rdata), int'(v));
    ram_rreq = 0; ram_wreq = 0;
    @(negedge clk);
    check("R5 ram ack held", int'(ram_ack), 1);
    @(negedge clk);
    check("R5 ram ack cleared", int'(ram_ack), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset acks", int'({rom_aack, rom_dack, ram_ack}), 0);
    check("R10 reset rom data", int'(rom_rdata), 0);
    check("R10 reset ram data", int'(ram_rdata), 0);
    rst_n = 1;

    for (int k = 0; k < NVEC; k++) begin
      case (VEC[k][15:14])
        2'd0: rom_access(VEC[k][13:8]);
        2'd1: ram_access(1'b1, VEC[k][13:8], VEC[k][7:0]);
        default: ram_access(1'b0, VEC[k][13:8], VEC[k][7:0]);
      endcase
    end

    // R3: one request alone does nothing
    @(negedge clk);
    rom_addr = 6'd9; rom_areq = 1;
    repeat (6) @(negedge clk);
    check("R3 lone areq no ack", int'({rom_aack, rom_dack}), 0);
    rom_dreq = 1;
    wait_ack(1, lat);
    check("R3 join after dreq", lat, LAT + 2);
    check("R1 rom word 9", int'(rom_rdata), int'(exp_rom(9)));
    // R2: dropping one request keeps the handshake high
    rom_areq = 0;
    repeat (4) @(negedge clk);
    check("R2 one req low holds acks", int'({rom_aack, rom_dack}), 3);
    rom_dreq = 0;
    @(negedge clk);
    @(negedge clk);
    check("R2 both low releases", int'({rom_aack, rom_dack}), 0);

    // R9: re-request before acks have cleared
    rom_addr = 6'd40; rom_areq = 1; rom_dreq = 1;
    wait_ack(1, lat);
    rom_areq = 0; rom_dreq = 0;
    @(negedge clk);
    rom_addr = 6'd41; rom_areq = 1; rom_dreq = 1;
    @(negedge clk);
    check("R9 old acks cleared", int'({rom_aack, rom_dack}), 0);
    wait_ack(1, lat);
    check("R9 delayed start", lat + 1, LAT + 3);
    check("R9 new word", int'(rom_rdata), int'(exp_rom(41)));

    // R10: reset during an active acknowledge
    #2 rst_n = 0;
    #1 check("R10 async clear in reset", int'({rom_aack, rom_dack}), 0);
    rom_areq = 0; rom_dreq = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 idle after reset", int'({rom_aack, rom_dack, ram_ack}), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule